// File: doc/BRIEF.md
# Two-Entry Translation Shortcut Cache

This block sits in front of a translation lookaside buffer and remembers the two translations used most recently. Each slot holds the TLB entry index and a copy of that entry's virtual base, size mask and physical base. Each slot also holds the address-space tag that the access carried. A single snapshot of the 64-bit translation control word covers both slots and is taken whenever a slot is filled. A lookup that hits returns the physical address in the same cycle, with no TLB search.

On a miss, the surrounding logic runs the full TLB search. It then reports the entry that answered through the fill port. A newly reported entry moves to the front, and the older front entry drops to the back. Any change to the TLB contents, such as an insert or any kind of demap, is signalled on one modification input. That signal throws the whole cache away.

The block also splits the current control word into four fields: partition, trap level, primary context and secondary context. These fields are sent out for use by the neighbouring logic.

Top module: `tsc_shortcut`

## Requirements
- R1: After an asynchronous reset, `hit_o` is 0 until at least one fill has completed.
- R2: The field outputs decode the current control word at these bit positions: partition is bits 15:8, trap level is bits 18:16, primary context is bits 47:32 and secondary context is bits 63:48.
- R3: A lookup hits only if all of the following hold:
  - the cache is valid;
  - the control word snapshot equals the present `ctrl_word_i`;
  - an occupied slot has an address-space tag equal to `lk_space_i`.
  
  When both slots would hit, slot 0 wins, and `hit_slot_o` gives the winning slot (0 or 1).
- R4: The range test is strict on both sides: `base < vaddr + size` and `base + mask > vaddr`. An access that starts at `base + mask` misses.
- R5: On a hit, `paddr_o` is the slot's physical base with the bits under the mask cleared, ORed with `lk_vaddr_i & mask`.
- R6: A fill whose index is in neither occupied slot does three things: slot 0 moves to slot 1, the new entry goes into slot 0, and the old slot 1 is dropped.
- R7: A fill whose index is already in an occupied slot leaves both slots, including their tags, unchanged. It still refreshes the control word snapshot.
- R8: A fill while the cache is invalid first empties both slots, then writes slot 0, and then marks the cache valid. Slot 1 stays empty.
- R9: `tlb_mod_i` clears the valid flag on the next edge. If a fill arrives in the same cycle, the fill is dropped.
- R10: A fill with `fill_implicit_i` set stores an address-space tag of 0, whatever `fill_space_i` holds.
- R11: On a miss, `hit_slot_o` and `paddr_o` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ctrl_word_i | input | 64 | Current translation control word |
| part_id_o | output | 8 | Partition field |
| trap_lvl_o | output | 3 | Trap level field |
| pri_ctx_o | output | 16 | Primary context field |
| sec_ctx_o | output | 16 | Secondary context field |
| lk_vaddr_i | input | ADDR_W | Lookup virtual address |
| lk_size_i | input | SIZE_W | Lookup access size in bytes |
| lk_space_i | input | SPACE_W | Lookup address-space tag |
| hit_o | output | 1 | Lookup hit |
| hit_slot_o | output | 1 | Slot that hit |
| paddr_o | output | ADDR_W | Translated physical address |
| fill_i | input | 1 | Record a TLB hit into the cache |
| fill_idx_i | input | IDX_W | TLB entry index of the fill |
| fill_base_i | input | ADDR_W | Virtual base of the entry |
| fill_mask_i | input | ADDR_W | Page size minus one |
| fill_pbase_i | input | ADDR_W | Physical base of the entry |
| fill_space_i | input | SPACE_W | Address-space tag of the access |
| fill_implicit_i | input | 1 | Access was implicit; store tag 0 |
| tlb_mod_i | input | 1 | TLB contents changed; invalidate |

## Verification
A fixed table of lookups runs against two filled slots. The table covers these cases:
- hits in the front slot and in the back slot, which separate slot priority from slot contents;
- a tag mismatch inside a valid range;
- an access that starts below the base but overlaps it;
- accesses exactly at the lower and upper bounds, which tell a strict comparison from an inclusive one.

Directed sequences then cover the remaining cases:
- a change and a restore of the control word, which separates the snapshot comparison from the valid flag;
- a refill of an index already cached, which separates moving to the front from rewriting the slot;
- a third fill that evicts the back slot;
- an implicit fill;
- a fill in the same cycle as an invalidation;
- a fill into an invalid cache, after which the old back slot must not come back.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  localparam int CTRL_W  = 64;
  localparam int PART_LO = 8;
  localparam int PART_W  = 8;
  localparam int TL_LO   = 16;
  localparam int TL_W    = 3;
  localparam int PCTX_LO = 32;
  localparam int SCTX_LO = 48;
  localparam int CTX_W   = 16;
  localparam int NSLOT   = 2;

  typedef struct packed {
    logic [CTX_W-1:0]  sctx;
    logic [CTX_W-1:0]  pctx;
    logic [TL_W-1:0]   tl;
    logic [PART_W-1:0] part;
  } ctrl_fields_t;

  function automatic ctrl_fields_t split_ctrl(input logic [CTRL_W-1:0] w);
    ctrl_fields_t f;
    f.part = w[PART_LO +: PART_W];
    f.tl   = w[TL_LO +: TL_W];
    f.pctx = w[PCTX_LO +: CTX_W];
    f.sctx = w[SCTX_LO +: CTX_W];
    return f;
  endfunction
endpackage

// File: rtl/tsc_ctrl_decode.sv
module tsc_ctrl_decode
  import tsc_pkg::*;
(
  input  logic [CTRL_W-1:0] ctrl_i,
  output ctrl_fields_t      fields_o
);
  assign fields_o = split_ctrl(ctrl_i);
endmodule

// File: rtl/tsc_slot_match.sv
module tsc_slot_match #(
  parameter int ADDR_W  = 48,
  parameter int SIZE_W  = 5,
  parameter int SPACE_W = 8
) (
  input  logic               slot_on_i,
  input  logic [ADDR_W-1:0]  base_i,
  input  logic [ADDR_W-1:0]  mask_i,
  input  logic [ADDR_W-1:0]  pbase_i,
  input  logic [SPACE_W-1:0] space_i,
  input  logic [ADDR_W-1:0]  lk_vaddr_i,
  input  logic [SIZE_W-1:0]  lk_size_i,
  input  logic [SPACE_W-1:0] lk_space_i,
  output logic               match_o,
  output logic [ADDR_W-1:0]  paddr_o
);
  localparam int SUM_W = ADDR_W + 1;

  logic [SUM_W-1:0] va_end, pg_end;
  logic             lo_ok, hi_ok;

  always_comb begin
    va_end  = {1'b0, lk_vaddr_i} + SUM_W'(lk_size_i);
    pg_end  = {1'b0, base_i} + {1'b0, mask_i};
    lo_ok   = {1'b0, base_i} < va_end;
    hi_ok   = pg_end > {1'b0, lk_vaddr_i};
    match_o = slot_on_i && (space_i == lk_space_i) && lo_ok && hi_ok;
    paddr_o = (pbase_i & ~mask_i) | (lk_vaddr_i & mask_i);
  end
endmodule

// File: rtl/tsc_shortcut.sv
module tsc_shortcut
  import tsc_pkg::*;
#(
  parameter int ADDR_W  = 48,
  parameter int SIZE_W  = 5,
  parameter int SPACE_W = 8,
  parameter int IDX_W   = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [63:0]        ctrl_word_i,
  output logic [7:0]         part_id_o,
  output logic [2:0]         trap_lvl_o,
  output logic [15:0]        pri_ctx_o,
  output logic [15:0]        sec_ctx_o,
  input  logic [ADDR_W-1:0]  lk_vaddr_i,
  input  logic [SIZE_W-1:0]  lk_size_i,
  input  logic [SPACE_W-1:0] lk_space_i,
  output logic               hit_o,
  output logic               hit_slot_o,
  output logic [ADDR_W-1:0]  paddr_o,
  input  logic               fill_i,
  input  logic [IDX_W-1:0]   fill_idx_i,
  input  logic [ADDR_W-1:0]  fill_base_i,
  input  logic [ADDR_W-1:0]  fill_mask_i,
  input  logic [ADDR_W-1:0]  fill_pbase_i,
  input  logic [SPACE_W-1:0] fill_space_i,
  input  logic               fill_implicit_i,
  input  logic               tlb_mod_i
);
  ctrl_fields_t fields;

  tsc_ctrl_decode u_dec (.ctrl_i(ctrl_word_i), .fields_o(fields));

  assign part_id_o  = fields.part;
  assign trap_lvl_o = fields.tl;
  assign pri_ctx_o  = fields.pctx;
  assign sec_ctx_o  = fields.sctx;

  logic               valid_q;
  logic [CTRL_W-1:0]  state_q;
  logic [NSLOT-1:0]   on_q;
  logic [IDX_W-1:0]   idx_q   [NSLOT];
  logic [ADDR_W-1:0]  base_q  [NSLOT];
  logic [ADDR_W-1:0]  mask_q  [NSLOT];
  logic [ADDR_W-1:0]  pbase_q [NSLOT];
  logic [SPACE_W-1:0] space_q [NSLOT];

  // slots count as empty while the cache is invalid
  logic [NSLOT-1:0]   on_eff;
  logic               cached;
  logic [SPACE_W-1:0] new_space;

  always_comb begin
    on_eff    = valid_q ? on_q : '0;
    cached    = 1'b0;
    for (int s = 0; s < NSLOT; s++)
      if (on_eff[s] && idx_q[s] == fill_idx_i) cached = 1'b1;
    new_space = fill_implicit_i ? '0 : fill_space_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      state_q <= '0;
      on_q    <= '0;
      for (int s = 0; s < NSLOT; s++) begin
        idx_q[s]   <= '0;
        base_q[s]  <= '0;
        mask_q[s]  <= '0;
        pbase_q[s] <= '0;
        space_q[s] <= '0;
      end
    end else if (tlb_mod_i) begin
      valid_q <= 1'b0;
    end else if (fill_i) begin
      valid_q <= 1'b1;
      state_q <= ctrl_word_i;
      on_q    <= on_eff;
      if (!cached) begin
        on_q       <= {on_eff[0], 1'b1};
        idx_q[1]   <= idx_q[0];
        base_q[1]  <= base_q[0];
        mask_q[1]  <= mask_q[0];
        pbase_q[1] <= pbase_q[0];
        space_q[1] <= space_q[0];
        idx_q[0]   <= fill_idx_i;
        base_q[0]  <= fill_base_i;
        mask_q[0]  <= fill_mask_i;
        pbase_q[0] <= fill_pbase_i;
        space_q[0] <= new_space;
      end
    end
  end

  logic              ctx_ok;
  logic [NSLOT-1:0]  match;
  logic [ADDR_W-1:0] slot_pa [NSLOT];

  assign ctx_ok = valid_q && (state_q == ctrl_word_i);

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    tsc_slot_match #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .SPACE_W(SPACE_W)) u_match (
      .slot_on_i (on_q[g] && ctx_ok),
      .base_i    (base_q[g]),
      .mask_i    (mask_q[g]),
      .pbase_i   (pbase_q[g]),
      .space_i   (space_q[g]),
      .lk_vaddr_i(lk_vaddr_i),
      .lk_size_i (lk_size_i),
      .lk_space_i(lk_space_i),
      .match_o   (match[g]),
      .paddr_o   (slot_pa[g])
    );
  end

  always_comb begin
    hit_o      = |match;
    hit_slot_o = !match[0] && match[1];
    if (match[0])      paddr_o = slot_pa[0];
    else if (match[1]) paddr_o = slot_pa[1];
    else               paddr_o = '0;
  end
endmodule

// File: rtl/tsc_shortcut_chk.sv
module tsc_shortcut_chk #(
  parameter int ADDR_W  = 48,
  parameter int SPACE_W = 8,
  parameter int IDX_W   = 6
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [63:0]        ctrl_word_i,
  input logic [ADDR_W-1:0]  lk_vaddr_i,
  input logic [SPACE_W-1:0] lk_space_i,
  input logic               hit_o,
  input logic               hit_slot_o,
  input logic [ADDR_W-1:0]  paddr_o,
  input logic               fill_i,
  input logic [IDX_W-1:0]   fill_idx_i,
  input logic               fill_implicit_i,
  input logic               tlb_mod_i,
  input logic               valid_q,
  input logic [63:0]        state_q,
  input logic [1:0]         on_q,
  input logic [IDX_W-1:0]   idx_q   [2],
  input logic [ADDR_W-1:0]  mask_q  [2],
  input logic [SPACE_W-1:0] space_q [2]
);
  logic fresh;
  assign fresh = !(on_q[0] && idx_q[0] == fill_idx_i) && !(on_q[1] && idx_q[1] == fill_idx_i);

  assert_hit_needs_state_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> valid_q && state_q == ctrl_word_i);

  assert_front_tag_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o && !hit_slot_o |-> on_q[0] && space_q[0] == lk_space_i);

  assert_front_offset_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o && !hit_slot_o |-> ((paddr_o ^ lk_vaddr_i) & mask_q[0]) == '0);

  assert_move_front_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_i && !tlb_mod_i && valid_q && fresh |=>
      on_q[0] && idx_q[0] == $past(fill_idx_i) && idx_q[1] == $past(idx_q[0]));

  assert_cold_fill_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_i && !tlb_mod_i && !valid_q |=> valid_q && on_q == 2'b01);

  assert_flush_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tlb_mod_i |=> !hit_o && !valid_q);

  assert_implicit_tag_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_i && fill_implicit_i && !tlb_mod_i && !valid_q |=> space_q[0] == '0);

  assert_miss_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> !hit_slot_o && paddr_o == '0);
endmodule

bind tsc_shortcut tsc_shortcut_chk #(.ADDR_W(ADDR_W), .SPACE_W(SPACE_W), .IDX_W(IDX_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ctrl_word_i(ctrl_word_i),
  .lk_vaddr_i(lk_vaddr_i), .lk_space_i(lk_space_i),
  .hit_o(hit_o), .hit_slot_o(hit_slot_o), .paddr_o(paddr_o),
  .fill_i(fill_i), .fill_idx_i(fill_idx_i), .fill_implicit_i(fill_implicit_i),
  .tlb_mod_i(tlb_mod_i), .valid_q(valid_q), .state_q(state_q), .on_q(on_q),
  .idx_q(idx_q), .mask_q(mask_q), .space_q(space_q)
);

// File: tb/tsc_shortcut_test.sv
module tsc_shortcut_test;
  localparam int AW = 48;
  localparam int SW = 5;
  localparam int PW = 8;
  localparam int IW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [63:0]   ctrl = '0;
  logic [7:0]    part;
  logic [2:0]    tl;
  logic [15:0]   pctx, sctx;
  logic [AW-1:0] lk_va = '0;
  logic [SW-1:0] lk_sz = '0;
  logic [PW-1:0] lk_sp = '0;
  logic          hit, hslot;
  logic [AW-1:0] pa;
  logic          fill = 1'b0;
  logic [IW-1:0] f_idx = '0;
  logic [AW-1:0] f_base = '0, f_mask = '0, f_pbase = '0;
  logic [PW-1:0] f_sp = '0;
  logic          f_impl = 1'b0;
  logic          tmod = 1'b0;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  tsc_shortcut uut (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_word_i(ctrl),
    .part_id_o(part), .trap_lvl_o(tl), .pri_ctx_o(pctx), .sec_ctx_o(sctx),
    .lk_vaddr_i(lk_va), .lk_size_i(lk_sz), .lk_space_i(lk_sp),
    .hit_o(hit), .hit_slot_o(hslot), .paddr_o(pa),
    .fill_i(fill), .fill_idx_i(f_idx), .fill_base_i(f_base), .fill_mask_i(f_mask),
    .fill_pbase_i(f_pbase), .fill_space_i(f_sp), .fill_implicit_i(f_impl),
    .tlb_mod_i(tmod)
  );

  typedef struct packed {
    logic [AW-1:0] va;
    logic [SW-1:0] sz;
    logic [PW-1:0] sp;
    logic          eh;
    logic          es;
    logic [AW-1:0] ep;
  } vec_t;

  localparam logic [63:0] C1 = 64'h1111_2222_0005_0300;
  localparam logic [63:0] C2 = 64'hABCD_1234_0007_FF00;

  // slot0: idx 7, base 0x4000_0000, 64K page; slot1: idx 3, base 0x1000, 4K page
  localparam vec_t VECS [8] = '{
    '{48'h1234,     5'd8, 8'h80, 1'b1, 1'b1, 48'h80234},   // R3 back slot, R5
    '{48'h40001238, 5'd4, 8'h10, 1'b1, 1'b0, 48'h1231238}, // R3 front slot, R5
    '{48'h1234,     5'd8, 8'h10, 1'b0, 1'b0, 48'h0},       // R3 tag mismatch
    '{48'h0FFC,     5'd8, 8'h80, 1'b1, 1'b1, 48'h80FFC},   // R4 overlap below base
    '{48'h0FF8,     5'd8, 8'h80, 1'b0, 1'b0, 48'h0},       // R4 ends at base
    '{48'h1FFF,     5'd1, 8'h80, 1'b0, 1'b0, 48'h0},       // R4 strict upper
    '{48'h1FFE,     5'd1, 8'h80, 1'b1, 1'b1, 48'h80FFE},   // R4 just inside
    '{48'h2000,     5'd1, 8'h80, 1'b0, 1'b0, 48'h0}        // R11 beyond page
  };

  task automatic chk(input string req, input logic [AW-1:0] va, input logic [SW-1:0] sz,
                     input logic [PW-1:0] sp, input logic eh, input logic es,
                     input logic [AW-1:0] ep);
    @(negedge clk);
    lk_va = va; lk_sz = sz; lk_sp = sp;
    #1;
    n_chk++;
    if (hit !== eh || hslot !== es || pa !== ep) begin
      n_bad++;
      $display("FAIL %s va=%h: actual hit=%b slot=%b pa=%h expected hit=%b slot=%b pa=%h",
               req, va, hit, hslot, pa, eh, es, ep);
    end
  endtask

  task automatic do_fill(input logic [IW-1:0] idx, input logic [AW-1:0] b, input logic [AW-1:0] m,
                         input logic [AW-1:0] p, input logic [PW-1:0] s, input logic imp,
                         input logic mod);
    @(negedge clk);
    fill = 1'b1; f_idx = idx; f_base = b; f_mask = m; f_pbase = p; f_sp = s; f_impl = imp;
    tmod = mod;
    @(negedge clk);
    fill = 1'b0; f_impl = 1'b0; tmod = 1'b0;
  endtask

  task automatic chk_fields(input logic [63:0] w, input logic [7:0] ep, input logic [2:0] et,
                            input logic [15:0] e1, input logic [15:0] e2);
    @(negedge clk);
    ctrl = w;
    #1;
    n_chk++;
    if (part !== ep || tl !== et || pctx !== e1 || sctx !== e2) begin
      n_bad++;
      $display("FAIL R2: actual %h/%h/%h/%h expected %h/%h/%h/%h",
               part, tl, pctx, sctx, ep, et, e1, e2);
    end
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL R1 watchdog: actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1", 48'h1234, 5'd8, 8'h80, 1'b0, 1'b0, 48'h0);
    chk_fields(C2, 8'hFF, 3'd7, 16'h1234, 16'hABCD);
    chk_fields(C1, 8'h03, 3'd5, 16'h2222, 16'h1111);

    // R8 cold fill, R6 second fill moves to front
    do_fill(6'd3, 48'h1000, 48'hFFF, 48'h80000, 8'h80, 1'b0, 1'b0);
    do_fill(6'd7, 48'h40000000, 48'hFFFF, 48'h1230000, 8'h10, 1'b0, 1'b0);
    for (int i = 0; i < 8; i++)
      chk("R3/R4/R5 table", VECS[i].va, VECS[i].sz, VECS[i].sp, VECS[i].eh, VECS[i].es, VECS[i].ep);

    // R3 snapshot mismatch then restore
    chk_fields(C2, 8'hFF, 3'd7, 16'h1234, 16'hABCD);
    chk("R3 ctrl changed", 48'h1234, 5'd8, 8'h80, 1'b0, 1'b0, 48'h0);
    chk_fields(C1, 8'h03, 3'd5, 16'h2222, 16'h1111);
    chk("R3 ctrl restored", 48'h1234, 5'd8, 8'h80, 1'b1, 1'b1, 48'h80234);

    // R7 refill of cached index: tag 0x55 ignored, stays in back slot
    do_fill(6'd3, 48'h1000, 48'hFFF, 48'h80000, 8'h55, 1'b0, 1'b0);
    chk("R7 no move", 48'h1234, 5'd8, 8'h80, 1'b1, 1'b1, 48'h80234);
    chk("R7 tag kept", 48'h1234, 5'd8, 8'h55, 1'b0, 1'b0, 48'h0);

    // R6 eviction, R10 implicit tag
    do_fill(6'd9, 48'h9000, 48'hFFF, 48'h300000, 8'h77, 1'b1, 1'b0);
    chk("R10 tag zero", 48'h9010, 5'd4, 8'h00, 1'b1, 1'b0, 48'h300010);
    chk("R10 given tag dropped", 48'h9010, 5'd4, 8'h77, 1'b0, 1'b0, 48'h0);
    chk("R6 old front to back", 48'h40000008, 5'd8, 8'h10, 1'b1, 1'b1, 48'h1230008);
    chk("R6 old back evicted", 48'h1234, 5'd8, 8'h80, 1'b0, 1'b0, 48'h0);

    // R9 flush
    @(negedge clk); tmod = 1'b1;
    @(negedge clk); tmod = 1'b0;
    chk("R9 flushed", 48'h9010, 5'd4, 8'h00, 1'b0, 1'b0, 48'h0);

    // R8 cold fill empties both slots
    do_fill(6'd3, 48'h1000, 48'hFFF, 48'h80000, 8'h80, 1'b0, 1'b0);
    chk("R8 new front", 48'h1010, 5'd8, 8'h80, 1'b1, 1'b0, 48'h80010);
    chk("R8 back empty", 48'h9010, 5'd4, 8'h00, 1'b0, 1'b0, 48'h0);

    // R9 fill with flush in same cycle is dropped
    do_fill(6'd9, 48'h9000, 48'hFFF, 48'h300000, 8'h00, 1'b0, 1'b1);
    chk("R9 fill dropped", 48'h9010, 5'd4, 8'h00, 1'b0, 1'b0, 48'h0);
    chk("R9 invalid", 48'h1010, 5'd8, 8'h80, 1'b0, 1'b0, 48'h0);

    // R1 reset mid-run
    do_fill(6'd3, 48'h1000, 48'hFFF, 48'h80000, 8'h80, 1'b0, 1'b0);
    chk("R1 before reset", 48'h1010, 5'd8, 8'h80, 1'b1, 1'b0, 48'h80010);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    chk("R1 after reset", 48'h1010, 5'd8, 8'h80, 1'b0, 1'b0, 48'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule